// File: doc/BRIEF.md
# Stripe Lane Selector

This block chooses over how many serial data output lanes an audio stream should be spread. Software or a stream sequencer gives it the stream's channel count, sample width, sample rate, the 2-bit lane capability field and a minimum load each lane should carry. It pulses `start`, and a few cycles later `done` pulses with a 2-bit stripe code.

The stream load is channels times sample bits. For rates above 48000 it is multiplied by the whole number of 48000 steps in the rate. The block tries lane counts from the largest the capability allows and halves the count after each trial. Each trial divides the load by the lane count and compares the result with the limit. The first count that meets the limit sets the code. If no count meets it, the code is zero.

Top module: `stripe_lane_sel`

## Requirements
- R1: A `start` pulse accepted while idle captures all operand inputs; changes to them afterwards do not alter that run's result.
- R2: The capability field encodes the starting lane count: 0 means no trial (code 0), 1 means two lanes, 2 means four lanes; 3 is reserved and is treated as four lanes.
- R3: The rate factor is the integer quotient rate/48000 when the rate exceeds 48000, and 1 otherwise (48000 itself gives factor 1).
- R4: The load of a trial is floor(channels × bits × factor / lanes).
- R5: Trials go from the starting lane count downward, halving each time. The first trial whose load is greater than or equal to the limit ends the search, with code = lanes/2 (1 lane → 0, 2 → 1, 4 → 2).
- R6: When no lane count meets the limit, the code is 0.
- R7: `done` is high for exactly one cycle per run. `stripeCode` changes only in a cycle where `done` is high, holds until the next completion, and is never 3.
- R8: A `start` pulse while a run is in progress is ignored.
- R9: `done` rises no more than 12 cycles after the edge that accepted `start`.
- R10: After reset, `done` and `stripeCode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse; captures operands |
| chanCount | input | CH_W | Channel count |
| sampleBits | input | BITS_W | Bits per sample |
| sampleRate | input | RATE_W | Sample rate in Hz |
| laneCapField | input | 2 | Lane capability field (bits 2:1 of the capability word) |
| loadLimit | input | LOAD_W | Minimum per-lane load |
| done | output | 1 | One-cycle completion pulse |
| stripeCode | output | 2 | Selected stripe code, held between runs |

## Verification
The sweep crosses channel counts 1 to 16, sample widths 8 to 32, rates below, at, just above and far above 48000, all four capability values and limits from zero to unreachable. Rates 48000 and 48001 show whether the factor boundary is right. Zero and all-ones limits show the top lane count and the fall-through to code 0. Directed cases with loads that do not divide evenly check the floor rounding at each lane count. Every run changes the operands and pulses `start` again while the run is busy, to show that operands are captured once and that a start during a run is ignored.

// File: rtl/stripe_sel_pkg.sv
package stripe_sel_pkg;

  typedef struct packed {
    logic capture;
    logic divStep;
    logic mulLoad;
    logic halve;
    logic finish;
  } stripe_ctrl_t;

  typedef struct packed {
    logic remGe;
    logic hit;
    logic lastTrial;
  } stripe_stat_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIV    = 2'd1,
    ST_SEARCH = 2'd2
  } stripe_state_t;

endpackage

// File: rtl/stripe_sel_dp.sv
module stripe_sel_dp
  import stripe_sel_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int BITS_W    = 6,
  parameter int RATE_W    = 18,
  parameter int LOAD_W    = 32,
  parameter int BASE_RATE = 48000
) (
  input  logic              clk,
  input  logic              rstN,
  input  stripe_ctrl_t      ctrl,
  input  logic [CH_W-1:0]   chanCount,
  input  logic [BITS_W-1:0] sampleBits,
  input  logic [RATE_W-1:0] sampleRate,
  input  logic [1:0]        laneCapField,
  input  logic [LOAD_W-1:0] loadLimit,
  output stripe_stat_t      stat,
  output logic [1:0]        stripeCode
);

  localparam int Q_W    = $clog2((2 ** RATE_W) / BASE_RATE + 2);
  localparam int LANE_W = 3;

  logic [CH_W-1:0]   chR;
  logic [BITS_W-1:0] bitsR;
  logic [LOAD_W-1:0] limitR;
  logic [RATE_W-1:0] remR;
  logic [Q_W-1:0]    quoR;
  logic [LOAD_W-1:0] baseR;
  logic [LANE_W-1:0] laneR;
  logic [1:0]        codeR;

  logic [Q_W-1:0]    factor;
  logic [LOAD_W-1:0] laneLoad;
  logic [LANE_W-1:0] startLanes;

  // Factor is at least one: rates at or below the base step use the raw load.
  assign factor = (quoR == '0) ? Q_W'(1) : quoR;

  always_comb begin
    case (laneCapField)
      2'd0:    startLanes = 3'd0;
      2'd1:    startLanes = 3'd2;
      default: startLanes = 3'd4;
    endcase
  end

  // Lane counts are powers of two, so the per-lane division is a shift.
  always_comb begin
    case (laneR)
      3'd4:    laneLoad = baseR >> 2;
      3'd2:    laneLoad = baseR >> 1;
      default: laneLoad = baseR;
    endcase
  end

  assign stat.remGe     = (remR >= RATE_W'(BASE_RATE));
  assign stat.hit       = (laneR != '0) && (laneLoad >= limitR);
  assign stat.lastTrial = (laneR <= 3'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chR    <= '0;
      bitsR  <= '0;
      limitR <= '0;
      remR   <= '0;
      quoR   <= '0;
      baseR  <= '0;
      laneR  <= '0;
      codeR  <= '0;
    end else begin
      if (ctrl.capture) begin
        chR    <= chanCount;
        bitsR  <= sampleBits;
        limitR <= loadLimit;
        remR   <= sampleRate;
        quoR   <= '0;
        laneR  <= startLanes;
      end
      if (ctrl.divStep) begin
        remR <= remR - RATE_W'(BASE_RATE);
        quoR <= quoR + Q_W'(1);
      end
      if (ctrl.mulLoad)
        baseR <= LOAD_W'(chR) * LOAD_W'(bitsR) * LOAD_W'(factor);
      if (ctrl.halve)
        laneR <= laneR >> 1;
      if (ctrl.finish)
        codeR <= stat.hit ? laneR[2:1] : 2'b00;
    end
  end

  assign stripeCode = codeR;

endmodule

// File: rtl/stripe_sel_ctrl.sv
module stripe_sel_ctrl
  import stripe_sel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  stripe_stat_t stat,
  output stripe_ctrl_t ctrl,
  output logic         done
);

  stripe_state_t stateR, stateN;
  logic          doneR;

  always_comb begin
    ctrl   = '0;
    stateN = stateR;
    case (stateR)
      ST_IDLE: begin
        if (start) begin
          ctrl.capture = 1'b1;
          stateN       = ST_DIV;
        end
      end
      ST_DIV: begin
        if (stat.remGe) begin
          ctrl.divStep = 1'b1;
        end else begin
          ctrl.mulLoad = 1'b1;
          stateN       = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (stat.hit || stat.lastTrial) begin
          ctrl.finish = 1'b1;
          stateN      = ST_IDLE;
        end else begin
          ctrl.halve = 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      doneR  <= 1'b0;
    end else begin
      stateR <= stateN;
      doneR  <= ctrl.finish;
    end
  end

  assign done = doneR;

endmodule

// File: rtl/stripe_lane_sel.sv
module stripe_lane_sel
  import stripe_sel_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int BITS_W    = 6,
  parameter int RATE_W    = 18,
  parameter int LOAD_W    = 32,
  parameter int BASE_RATE = 48000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CH_W-1:0]   chanCount,
  input  logic [BITS_W-1:0] sampleBits,
  input  logic [RATE_W-1:0] sampleRate,
  input  logic [1:0]        laneCapField,
  input  logic [LOAD_W-1:0] loadLimit,
  output logic              done,
  output logic [1:0]        stripeCode
);

  stripe_ctrl_t ctrl;
  stripe_stat_t stat;

  stripe_sel_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctrl  (ctrl),
    .done  (done)
  );

  stripe_sel_dp #(
    .CH_W      (CH_W),
    .BITS_W    (BITS_W),
    .RATE_W    (RATE_W),
    .LOAD_W    (LOAD_W),
    .BASE_RATE (BASE_RATE)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .chanCount    (chanCount),
    .sampleBits   (sampleBits),
    .sampleRate   (sampleRate),
    .laneCapField (laneCapField),
    .loadLimit    (loadLimit),
    .stat         (stat),
    .stripeCode   (stripeCode)
  );

endmodule

// File: rtl/stripe_lane_sel_chk.sv
module stripe_lane_sel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] laneCapField,
  input logic       done,
  input logic [1:0] stripeCode
);

  logic       busy;
  logic [1:0] capR;
  logic [4:0] cnt;
  logic [1:0] capMax;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      capR <= '0;
      cnt  <= '0;
    end else if (start && (!busy || done)) begin
      busy <= 1'b1;
      capR <= laneCapField;
      cnt  <= 5'd1;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 5'd1;
    end
  end

  assign capMax = (capR == 2'd0) ? 2'd0 : (capR == 2'd1) ? 2'd1 : 2'd2;

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(stripeCode));

  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    stripeCode != 2'b11);

  p_code_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> stripeCode <= capMax);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> cnt <= 5'd12);

  p_done_only_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

bind stripe_lane_sel stripe_lane_sel_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .laneCapField (laneCapField),
  .done         (done),
  .stripeCode   (stripeCode)
);

// File: tb/stripe_lane_sel_tb.sv
`timescale 1ns/1ps
module stripe_lane_sel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  chanCount = '0;
  logic [5:0]  sampleBits = '0;
  logic [17:0] sampleRate = '0;
  logic [1:0]  laneCapField = '0;
  logic [31:0] loadLimit = '0;
  logic        done;
  logic [1:0]  stripeCode;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  stripe_lane_sel dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .chanCount    (chanCount),
    .sampleBits   (sampleBits),
    .sampleRate   (sampleRate),
    .laneCapField (laneCapField),
    .loadLimit    (loadLimit),
    .done         (done),
    .stripeCode   (stripeCode)
  );

  function automatic logic [1:0] refCode(int ch, int bits, int rate, int fld,
                                         logic [31:0] lim);
    logic [31:0] base;
    int f;
    int lanes;
    f     = (rate > 48000) ? rate / 48000 : 1;
    base  = 32'(ch * bits * f);
    lanes = (fld == 0) ? 0 : (fld == 1) ? 2 : 4;
    while (lanes > 0) begin
      if ((base / 32'(lanes)) >= lim) break;
      lanes = lanes >> 1;
    end
    return 2'(lanes >> 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runOne(input int ch, input int bits, input int rate, input int fld,
                        input logic [31:0] lim, input string req);
    logic [1:0] exp;
    logic [1:0] held;
    int n;
    exp = refCode(ch, bits, rate, fld, lim);
    @(negedge clk);
    chanCount = 5'(ch); sampleBits = 6'(bits); sampleRate = 18'(rate);
    laneCapField = 2'(fld); loadLimit = lim; start = 1'b1;
    @(negedge clk);
    // R1: scramble operands after capture
    start = 1'b0;
    chanCount = ~chanCount; sampleBits = ~sampleBits; sampleRate = ~sampleRate;
    laneCapField = ~laneCapField; loadLimit = ~loadLimit;
    @(negedge clk);
    start = 1'b1;   // R8: start during a run must be ignored
    @(negedge clk);
    start = 1'b0;
    n = 3;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1 && n <= 12, "R9", n, 12);
    check(stripeCode == exp, req, stripeCode, exp);
    held = stripeCode;
    @(negedge clk);
    check(done == 1'b0 && stripeCode == held, "R7", {done, stripeCode}, {1'b0, held});
  endtask

  function automatic logic [31:0] limitOf(int i);
    case (i)
      0: return 32'd0;
      1: return 32'd64;
      2: return 32'd128;
      3: return 32'd384;
      4: return 32'd1000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int rateOf(int i);
    case (i)
      0: return 8000;
      1: return 44100;
      2: return 48000;
      3: return 48001;
      4: return 96000;
      5: return 192000;
      default: return 262143;
    endcase
  endfunction

  initial begin
    #(20ns * 190000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(done == 1'b0 && stripeCode == 2'd0, "R10", {done, stripeCode}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && stripeCode == 2'd0, "R10", {done, stripeCode}, 0);

    // R4: exact and floored per-lane loads
    runOne(2, 16, 48000, 2, 32'd8, "R4");   // 32/4 = 8 meets 8 -> 2
    runOne(2, 16, 48000, 2, 32'd9, "R4");   // 8 < 9, 16 >= 9 -> 1
    runOne(3, 7, 44100, 2, 32'd5, "R4");    // floor(21/4) = 5 -> 2
    runOne(3, 7, 44100, 2, 32'd6, "R4");    // 5 < 6, 10 -> 1
    runOne(3, 7, 44100, 1, 32'd11, "R4");   // 10 < 11, 21 -> 0
    // R3: factor boundary
    runOne(1, 8, 48000, 1, 32'd8, "R3");    // factor 1: 4 < 8, 8 -> 0
    runOne(1, 8, 96000, 1, 32'd8, "R3");    // factor 2: 8 -> 1
    runOne(1, 8, 95999, 1, 32'd8, "R3");    // factor 1 -> 0
    // R2: reserved field behaves as four lanes; zero field gives 0
    runOne(16, 32, 192000, 3, 32'd0, "R2");
    runOne(16, 32, 192000, 0, 32'd0, "R2");
    // R6: nothing qualifies
    runOne(1, 8, 8000, 2, 32'd9, "R6");

    // Sweep (R5 main function)
    for (int c = 0; c < 5; c++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 7; r++)
          for (int f = 0; f < 4; f++)
            for (int l = 0; l < 6; l++) begin
              int ch;
              int bits;
              string req;
              logic [31:0] lim;
              ch   = 1 << c;
              bits = 8 * (b + 1);
              lim  = limitOf(l);
              if (f == 0) req = "R2";
              else if (refCode(ch, bits, rateOf(r), f, lim) == 2'd0 &&
                       refCode(ch, bits, rateOf(r), 1, lim) == 2'd0 &&
                       32'(ch * bits * ((rateOf(r) > 48000) ? rateOf(r) / 48000 : 1)) < lim)
                req = "R6";
              else if (rateOf(r) > 48000) req = "R3";
              else req = "R5";
              runOne(ch, bits, rateOf(r), f, lim, req);
            end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule